// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Chain

This block is the boundary-scan data register for a bank of bidirectional pins. Each pin owns two serial cells. The data cell carries the pin's value, and the control cell carries the pin's driver-disable bit. Every cell has a capture/shift flip-flop and an update latch behind it. Serial data enters at the cell nearest the test data input and leaves the chain from cell 0, toward the test data output. Within each pin pair, the control cell sits on the input side of the data cell.

The test access port controller (not part of this block) provides three strobes: capture, shift and update. It also provides a test-mode bit, which is set for the instructions that drive the pins from the register. In normal mode, the core's output data and output enable pass straight through to the pad. In test mode, the pad is driven from the update latches. A control latch value of 1 turns the driver off. Reset loads 1 into every control cell, so in test mode all pins float until new values are loaded. The same chain serves observe-only use (capture and shift with test mode off) as well as pin-driving use.

Top module: `bscan_bidir_chain`

## Requirements
- R1: Pin p owns cell 2p (data) and cell 2p+1 (control). When shift_dr is high and capture_dr is low, every cell takes the value of the cell above it on the rising clock, the highest cell takes tdi, and tdo (the shift flop of cell 0) shows the new cell 0 value after that edge.
- R2: On a clock edge with capture_dr high, data cell 2p loads pad_in[p] and control cell 2p+1 loads the inverse of core_oe[p], so a captured 1 in a control cell means the driver was off.
- R3: When capture_dr and shift_dr are both high, the capture takes effect and no shift happens.
- R4: The update latches load from the shift flops only on a clock edge with update_dr high. Capture, shift and idle cycles leave pad_out and pad_oe unchanged while test_mode is 1.
- R5: With test_mode at 1, pad_out[p] equals the update latch of cell 2p and pad_oe[p] equals the inverse of the update latch of cell 2p+1 (latch value 1 = driver disabled, pad_oe 0).
- R6: With test_mode at 0, pad_out equals core_out and pad_oe equals core_oe, bit for bit, whatever the latches hold.
- R7: Reset (rst_n low, asserted asynchronously, released through a two-flop synchronizer) sets every control cell, shift flop and latch, to 1 and every data cell to 0. After reset, with test_mode at 1, pad_oe is all 0 and pad_out is all 0 until an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data into the highest cell |
| capture_dr | input | 1 | Capture strobe for the whole chain |
| shift_dr | input | 1 | Shift strobe, one position per clock |
| update_dr | input | 1 | Update strobe, copies shift flops into latches |
| test_mode | input | 1 | 1: pads driven from latches; 0: core passes through |
| core_out | input | NUM_PINS | Core output data per pin |
| core_oe | input | NUM_PINS | Core output enable per pin, 1 = drive |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data toward each pad driver |
| pad_oe | output | NUM_PINS | Driver enable per pad, 1 = drive |
| tdo | output | 1 | Serial data out of cell 0 |

## Verification
The bench uses a four-pin chain and goes through all 256 patterns of the eight cells. For each pattern it captures pad and enable values, reads them out, and shifts the pattern in. A chain with a swapped pair order, or with the control polarity left uninverted, would produce a readout stream in the wrong order or with its odd bits flipped. A chain whose latches follow the shift flops would show pins toggling mid-shift, and the bench watches the pads on every shift cycle to catch this. The bench also applies capture and shift in the same cycle, since a design that let the shift win would show the wrong bit on tdo. It checks that test mode after reset leaves every pin undriven, because a design that clears its control cells to 0 would drive every pin low at once.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic {CELL_DATA = 1'b0, CELL_CTRL = 1'b1} cell_kind_e;

  function automatic logic safe_value(cell_kind_e kind);
    return (kind == CELL_CTRL);
  endfunction
endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
  import bsc_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_DATA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic cap_val,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);
  localparam logic RST_VAL = safe_value(KIND);

  logic sh_q, sh_d;
  logic up_q, up_d;

  // capture has priority over shift
  always_comb begin
    sh_d = sh_q;
    if (capture_en)    sh_d = cap_val;
    else if (shift_en) sh_d = ser_in;
  end

  always_comb begin
    up_d = up_q;
    if (update_en) up_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= RST_VAL;
      up_q <= RST_VAL;
    end else begin
      sh_q <= sh_d;
      up_q <= up_d;
    end
  end

  assign ser_q = sh_q;
  assign upd_q = up_q;
endmodule

// File: rtl/bsc_pin_mux.sv
module bsc_pin_mux #(
  parameter int NUM_PINS = 62
) (
  input  logic                test_mode,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] data_latch,
  input  logic [NUM_PINS-1:0] ctrl_latch,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  always_comb begin
    if (test_mode) begin
      pad_out = data_latch;
      pad_oe  = ~ctrl_latch;   // latch 1 = driver off
    end else begin
      pad_out = core_out;
      pad_oe  = core_oe;
    end
  end
endmodule

// File: rtl/bscan_bidir_chain.sv
module bscan_bidir_chain
  import bsc_pkg::*;
#(
  parameter int NUM_PINS = 62
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tdi,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                test_mode,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                tdo
);
  localparam int CELLS = 2 * NUM_PINS;

  logic              rst_core_n;
  logic [CELLS:0]    link;        // link[i] = shift flop of cell i, link[CELLS] = tdi
  logic [NUM_PINS-1:0] data_latch;
  logic [NUM_PINS-1:0] ctrl_latch;

  bsc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign link[CELLS] = tdi;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    bsc_cell #(.KIND(CELL_CTRL)) ctrl_cell_i (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .capture_en (capture_dr),
      .shift_en   (shift_dr),
      .update_en  (update_dr),
      .cap_val    (~core_oe[p]),
      .ser_in     (link[2*p+2]),
      .ser_q      (link[2*p+1]),
      .upd_q      (ctrl_latch[p])
    );

    bsc_cell #(.KIND(CELL_DATA)) data_cell_i (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .capture_en (capture_dr),
      .shift_en   (shift_dr),
      .update_en  (update_dr),
      .cap_val    (pad_in[p]),
      .ser_in     (link[2*p+1]),
      .ser_q      (link[2*p]),
      .upd_q      (data_latch[p])
    );
  end

  bsc_pin_mux #(.NUM_PINS(NUM_PINS)) pin_mux_i (
    .test_mode  (test_mode),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .data_latch (data_latch),
    .ctrl_latch (ctrl_latch),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  assign tdo = link[0];
endmodule

// File: rtl/bscan_bidir_chain_chk.sv
module bscan_bidir_chain_chk #(
  parameter int NUM_PINS = 62
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tdi,
  input logic                capture_dr,
  input logic                shift_dr,
  input logic                update_dr,
  input logic                test_mode,
  input logic [NUM_PINS-1:0] core_out,
  input logic [NUM_PINS-1:0] core_oe,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                tdo,
  input logic                top_cell
);
  logic seen_upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_upd_q <= 1'b0;
    else if (update_dr) seen_upd_q <= 1'b1;
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> (top_cell == $past(tdi))); // R1

  AST_CAPTURE_PAD0: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && !shift_dr) |=> (tdo == $past(pad_in[0]))); // R2

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && shift_dr) |=> (tdo == $past(pad_in[0]))); // R3

  AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !update_dr) |=> (!test_mode || ($stable(pad_out) && $stable(pad_oe)))); // R4

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (pad_out == core_out && pad_oe == core_oe)); // R6

  AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !seen_upd_q) |-> (pad_oe == '0 && pad_out == '0)); // R7
endmodule

bind bscan_bidir_chain bscan_bidir_chain_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .tdi        (tdi),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .test_mode  (test_mode),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .tdo        (tdo),
  .top_cell   (link[CELLS-1])
);

// File: tb/bscan_bidir_chain_tb_top.sv
module bscan_bidir_chain_tb_top;
  localparam int NP = 4;
  localparam int NC = 2 * NP;

  logic clk = 1'b0;
  logic rst_n;
  logic tdi, capture_dr, shift_dr, update_dr, test_mode;
  logic [NP-1:0] core_out, core_oe, pad_in;
  logic [NP-1:0] pad_out, pad_oe;
  logic tdo;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  bscan_bidir_chain #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .test_mode(test_mode),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .tdo(tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected capture image: data cell 2p = pad_in[p], control 2p+1 = ~core_oe[p]
  function automatic logic [NC-1:0] cap_image(input logic [NP-1:0] pin, input logic [NP-1:0] oe);
    logic [NC-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[2*p]   = pin[p];
      v[2*p+1] = ~oe[p];
    end
    return v;
  endfunction

  // shift NC bits in while comparing NC bits out; pads must hold (R4)
  task automatic scan(input logic [NC-1:0] bits_in, input logic [NC-1:0] exp_out, input string req);
    logic [NP-1:0] po0, oe0;
    po0 = pad_out;
    oe0 = pad_oe;
    shift_dr = 1'b1;
    for (int k = 0; k < NC; k++) begin
      check(req, {31'd0, tdo}, {31'd0, exp_out[k]});
      tdi = bits_in[k];
      step();
      check("R4 pads steady during shift", {24'd0, pad_out, pad_oe}, {24'd0, po0, oe0});
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic expect_pads(input logic [NC-1:0] v, input string req);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      eo[p] = v[2*p];
      ee[p] = ~v[2*p+1];
    end
    check(req, {24'd0, pad_out, pad_oe}, {24'd0, eo, ee});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [NC-1:0] prev;
    rst_n = 1'b0;
    tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0; test_mode = 1'b1;
    core_out = '0; core_oe = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    // R7: reset state, test mode pads all undriven and low, tdo from data cell 0
    check("R7 reset pad_oe", {28'd0, pad_oe}, 32'd0);
    check("R7 reset pad_out", {28'd0, pad_out}, 32'd0);
    check("R7 reset tdo", {31'd0, tdo}, 32'd0);
    rst_n = 1'b1;
    repeat (3) step();

    // R7 + R1: read reset image (controls 1, data 0) without capture
    scan('0, 8'b1010_1010, "R7/R1 reset chain image");
    check("R7 still undriven before update", {28'd0, pad_oe}, 32'd0);

    // R2, R1, R4, R5: exhaustive over all cell patterns
    prev = '0;
    for (int b = 0; b < (1 << NC); b++) begin
      logic [NC-1:0] v;
      v = NC'(b);
      pad_in  = v[NP-1:0] ^ 4'h5;
      core_oe = v[NC-1:NP];
      capture_dr = 1'b1;
      step();
      capture_dr = 1'b0;
      check("R4 pads hold after capture", {24'd0, pad_out, pad_oe}, 32'(0));
      pad_in = ~pad_in;   // later pad changes must not matter
      scan(v, cap_image(v[NP-1:0] ^ 4'h5, v[NC-1:NP]), "R2/R1 captured stream");
      update_dr = 1'b1;
      step();
      update_dr = 1'b0;
      expect_pads(v, "R5 pads from latches");
      // prepare: send pads back to a known all-off state for next hold check
      scan(8'b1010_1010, v, "R1 shift-through of loaded pattern");
      update_dr = 1'b1;
      step();
      update_dr = 1'b0;
      prev = 8'b1010_1010;
      expect_pads(prev, "R5 pads back to safe image");
    end

    // R3: capture and shift together, capture wins
    pad_in = 4'b0001; core_oe = 4'b1111;
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b0;
    step();
    capture_dr = 1'b0; shift_dr = 1'b0;
    check("R3 capture over shift tdo", {31'd0, tdo}, 32'd1);
    pad_in = 4'b0000;
    scan('0, cap_image(4'b0001, 4'b1111), "R3 capture over shift image");

    // R4: shift a new pattern without update, pads keep old latches
    scan(8'b0101_0101, '0, "R4 shift without update");
    expect_pads(8'b1010_1010, "R4 no update no change");

    // R6: normal mode pass-through over all core combinations
    test_mode = 1'b0;
    for (int c = 0; c < (1 << NC); c++) begin
      core_out = c[NP-1:0];
      core_oe  = c[NC-1:NP];
      @(negedge clk);
      check("R6 pass-through", {24'd0, pad_out, pad_oe}, {24'd0, c[NP-1:0], c[NC-1:NP]});
    end
    // R6 with latches loaded: update while in normal mode, still passes through
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
    core_out = 4'b1001; core_oe = 4'b0110;
    @(negedge clk);
    check("R6 pass-through ignores latches", {24'd0, pad_out, pad_oe}, {24'd0, 4'b1001, 4'b0110});
    test_mode = 1'b1;
    @(negedge clk);
    expect_pads(8'b0101_0101, "R5 latches after normal-mode update");

    // R7: asynchronous reset returns latches to safe values
    rst_n = 1'b0;
    #1;
    check("R7 async reset pad_oe", {28'd0, pad_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    check("R7 after reset pad_out", {28'd0, pad_out}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule